// File: doc/BRIEF.md
# Receive Multicast and VLAN CAM Filter

This block sits beside an Ethernet receive path and decides, per frame header, whether the frame should be kept. It stores two small content-addressable tables: 32 multicast destination addresses (48 bits each) and 32 VLAN identifiers (16 bits stored, low 12 compared). Each table has its own 32-bit mask, and only entries whose mask bit is set take part in matching. After reset both masks are clear, so nothing matches until software enables entries.

Software reaches both tables through one byte-wide window made of a control register, an entry index, eight data bytes and four mask bytes. A table-select bit in the control register picks which table the window addresses. To write an entry, software opens access, writes the index and data bytes, pulses the write strobe, then clears the control register. A read strobe copies an entry back into the data bytes. A configuration register holds a promiscuous bit and a VLAN-filter enable bit.

For each header strobe the block reports a multicast hit, a VLAN hit and an accept decision, all registered one cycle later.

Top module: `rx_cam_filter`

## Requirements
- R1: After reset the control register (0x0C), the configuration register (0x0E), the index and both masks read zero, and no header produces a multicast or VLAN table hit.
- R2: Control register 0x0C: bit 0 opens access, bit 1 selects the VLAN table (0 selects multicast), bit 2 is the write strobe, bit 3 is the read strobe. While bit 0 is clear, writes to data (0x00-0x07), mask (0x08-0x0B) and index (0x0D) are ignored and reads of them return 0.
- R3: The index register (0x0D) keeps only its low 5 bits, so an index of 37 addresses entry 5 and reads back as 5.
- R4: A write strobe stores the data window into the indexed entry of the selected table. A multicast entry takes bytes 0x00-0x05, byte 0x00 being the first address byte (address bits 47:40). A VLAN entry takes 0x06 as its low byte and 0x07 as its high byte.
- R5: A read strobe copies the indexed entry of the selected table into the same data byte positions one cycle later. Both strobe bits read back 0 on the cycle after that.
- R6: Mask bytes 0x08-0x0B form one 32-bit mask, 0x08 holding bits 7:0 and bit i enabling entry i. Mask writes and reads go to the table named by the select bit.
- R7: The multicast hit is set when address bit 40 (group bit) is 1 and the address either equals an enabled multicast entry or is all ones. A unicast address never sets it.
- R8: The VLAN hit is set when the header is tagged and its 12-bit VID equals bits 11:0 of an enabled VLAN entry.
- R9: Configuration register 0x0E: bit 0 is promiscuous mode, which accepts every frame; bit 7 enables VLAN filtering. Otherwise a group-addressed frame without a multicast hit is rejected. With VLAN filtering on, a tagged frame without a VLAN hit is rejected. Untagged or unicast frames are not rejected by the respective filter.
- R10: Results are valid for exactly one cycle, one cycle after the header strobe. An entry write on the same clock edge as a header is not seen by that header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 8 | Register write data |
| regWr | input | 1 | Register write enable |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| hdrValid | input | 1 | Header strobe, one cycle per frame |
| hdrDa | input | 48 | Destination address, first byte in bits 47:40 |
| hdrTagged | input | 1 | Frame carries a VLAN tag |
| hdrVid | input | 12 | VLAN ID from the tag |
| resultValid | output | 1 | Results below are valid |
| mcHit | output | 1 | Multicast table or broadcast hit |
| vlanHit | output | 1 | VLAN table hit |
| accept | output | 1 | Final accept decision |

## Verification
Match results appear at the first clock edge after the header strobe. The bench therefore drives each header for one cycle starting on a falling edge and queues its expected verdict. A monitor on the following falling edge pops that verdict only when resultValid is high, and any result with nothing queued counts as a failure. Register reads are combinational and are sampled shortly after a falling edge. A read strobe's data is checked only after one full extra cycle, which is when the copied entry and the cleared strobe bits become visible. The same-edge case places the header exactly on the edge at which a pending write lands and expects the old table contents.

// File: rtl/cam_filter_pkg.sv
package cam_filter_pkg;
  localparam int CAM_IDX_W   = 5;
  localparam int CAM_ENTRIES = 1 << CAM_IDX_W;
  localparam int MAC_W       = 48;
  localparam int VID_W       = 12;
  localparam int VLAN_W      = 16;
  localparam int WIN_BYTES   = 8;

  localparam logic [7:0] ADDR_VLAN_LO = 8'h06;
  localparam logic [7:0] ADDR_MASK0   = 8'h08;
  localparam logic [7:0] ADDR_CTRL    = 8'h0C;
  localparam logic [7:0] ADDR_INDEX   = 8'h0D;
  localparam logic [7:0] ADDR_CFG     = 8'h0E;

  typedef struct packed {
    logic                 dataWr;
    logic [2:0]           dataByte;
    logic [7:0]           wrByte;
    logic                 maskWr;
    logic [1:0]           maskByte;
    logic                 entryWr;
    logic                 entryRd;
    logic                 vlanSel;
    logic [CAM_IDX_W-1:0] index;
  } camStrobe_t;
endpackage

// File: rtl/cam_reg_ctrl.sv
module cam_reg_ctrl
  import cam_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       regWr,
  output camStrobe_t stb,
  output logic [7:0] ctrlRdData,
  output logic       accessEn,
  output logic       promisc,
  output logic       vlanFiltEn
);
  localparam int PAD_W = 8 - CAM_IDX_W;

  logic                 vlanSel;
  logic                 wrPend;
  logic                 rdPend;
  logic [CAM_IDX_W-1:0] index;
  logic                 ctrlWrite;
  logic                 inDataRange;
  logic                 inMaskRange;

  assign ctrlWrite   = regWr && (regAddr == ADDR_CTRL);
  assign inDataRange = regAddr < ADDR_MASK0;
  assign inMaskRange = (regAddr >= ADDR_MASK0) && (regAddr < ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessEn   <= 1'b0;
      vlanSel    <= 1'b0;
      wrPend     <= 1'b0;
      rdPend     <= 1'b0;
      index      <= '0;
      promisc    <= 1'b0;
      vlanFiltEn <= 1'b0;
    end else begin
      wrPend <= 1'b0;
      rdPend <= 1'b0;
      if (regWr) begin
        case (regAddr)
          ADDR_CTRL: begin
            accessEn <= regWrData[0];
            vlanSel  <= regWrData[1];
            wrPend   <= regWrData[2] & regWrData[0];
            rdPend   <= regWrData[3] & regWrData[0];
          end
          ADDR_INDEX: if (accessEn) index <= regWrData[CAM_IDX_W-1:0];
          ADDR_CFG: begin
            promisc    <= regWrData[0];
            vlanFiltEn <= regWrData[7];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb.dataWr   = regWr && accessEn && inDataRange;
    stb.dataByte = regAddr[2:0];
    stb.wrByte   = regWrData;
    stb.maskWr   = regWr && accessEn && inMaskRange;
    stb.maskByte = regAddr[1:0];
    stb.entryWr  = wrPend;
    stb.entryRd  = rdPend;
    stb.vlanSel  = vlanSel;
    stb.index    = index;
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  ctrlRdData = {4'b0000, rdPend, wrPend, vlanSel, accessEn};
      ADDR_INDEX: ctrlRdData = accessEn ? {{PAD_W{1'b0}}, index} : 8'h00;
      ADDR_CFG:   ctrlRdData = {vlanFiltEn, 6'b000000, promisc};
      default:    ctrlRdData = 8'h00;
    endcase
  end

  // R5
  wr_strobe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && !ctrlWrite) |=> !wrPend);
  // R5
  rd_strobe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && !ctrlWrite) |=> !rdPend);
  // R2
  access_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !accessEn && regAddr == ADDR_INDEX) |=> $stable(index));
endmodule

// File: rtl/cam_match_dp.sv
module cam_match_dp
  import cam_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  camStrobe_t       stb,
  input  logic [7:0]       regAddr,
  input  logic             hdrValid,
  input  logic [MAC_W-1:0] hdrDa,
  input  logic             hdrTagged,
  input  logic [VID_W-1:0] hdrVid,
  input  logic             promisc,
  input  logic             vlanFiltEn,
  output logic [7:0]       dpRdData,
  output logic             resultValid,
  output logic             mcHit,
  output logic             vlanHit,
  output logic             accept
);
  localparam int ENTRIES   = CAM_ENTRIES;
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int GROUP_BIT = MAC_W - 8;

  logic [MAC_W-1:0]  mcTab [ENTRIES];
  logic [VLAN_W-1:0] vlTab [ENTRIES];
  logic [ENTRIES-1:0] mcMask, vlMask;
  logic [7:0]        dataWin [WIN_BYTES];
  logic [ENTRIES-1:0] mcEq, vlEq;
  logic [MAC_W-1:0]  winMac;
  logic [VLAN_W-1:0] winVlan;

  always_comb begin
    for (int b = 0; b < MAC_BYTES; b++)
      winMac[MAC_W-1-8*b -: 8] = dataWin[b];
    winVlan = {dataWin[ADDR_VLAN_LO[2:0] + 3'd1], dataWin[ADDR_VLAN_LO[2:0]]};
  end

  // entry storage: written only by the write strobe
  always_ff @(posedge clk) begin
    if (stb.entryWr) begin
      if (stb.vlanSel) vlTab[stb.index] <= winVlan;
      else             mcTab[stb.index] <= winMac;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcMask <= '0;
      vlMask <= '0;
    end else if (stb.maskWr) begin
      if (stb.vlanSel) vlMask[{stb.maskByte, 3'b000} +: 8] <= stb.wrByte;
      else             mcMask[{stb.maskByte, 3'b000} +: 8] <= stb.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < WIN_BYTES; b++) dataWin[b] <= 8'h00;
    end else if (stb.entryRd) begin
      if (stb.vlanSel) begin
        dataWin[ADDR_VLAN_LO[2:0]]        <= vlTab[stb.index][7:0];
        dataWin[ADDR_VLAN_LO[2:0] + 3'd1] <= vlTab[stb.index][15:8];
      end else begin
        for (int b = 0; b < MAC_BYTES; b++)
          dataWin[b] <= mcTab[stb.index][MAC_W-1-8*b -: 8];
      end
    end else if (stb.dataWr) begin
      dataWin[stb.dataByte] <= stb.wrByte;
    end
  end

  always_comb begin
    if (regAddr < ADDR_MASK0)
      dpRdData = dataWin[regAddr[2:0]];
    else if (stb.vlanSel)
      dpRdData = vlMask[{regAddr[1:0], 3'b000} +: 8];
    else
      dpRdData = mcMask[{regAddr[1:0], 3'b000} +: 8];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign mcEq[i] = mcMask[i] && (mcTab[i] == hdrDa);
    assign vlEq[i] = vlMask[i] && (vlTab[i][VID_W-1:0] == hdrVid);
  end

  logic isGroup, isBcast, mcNext, vlNext, accNext;
  always_comb begin
    isGroup = hdrDa[GROUP_BIT];
    isBcast = &hdrDa;
    mcNext  = isGroup && (isBcast || (|mcEq));
    vlNext  = hdrTagged && (|vlEq);
    accNext = promisc ||
              ((!isGroup || mcNext) && (!vlanFiltEn || !hdrTagged || vlNext));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      mcHit       <= 1'b0;
      vlanHit     <= 1'b0;
      accept      <= 1'b0;
    end else begin
      resultValid <= hdrValid;
      if (hdrValid) begin
        mcHit   <= mcNext;
        vlanHit <= vlNext;
        accept  <= accNext;
      end
    end
  end

  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.maskWr) |-> ($stable(mcMask) && $stable(vlMask)));
  // R10
  result_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> resultValid);
  // R10
  result_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !resultValid);
  // R7
  unicast_no_mc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hdrDa[GROUP_BIT]) |=> !mcHit);
  // R8
  untagged_no_vlan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hdrTagged) |=> !vlanHit);
endmodule

// File: rtl/rx_cam_filter.sv
module rx_cam_filter
  import cam_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic             regWr,
  output logic [7:0]       regRdData,
  input  logic             hdrValid,
  input  logic [MAC_W-1:0] hdrDa,
  input  logic             hdrTagged,
  input  logic [VID_W-1:0] hdrVid,
  output logic             resultValid,
  output logic             mcHit,
  output logic             vlanHit,
  output logic             accept
);
  camStrobe_t stb;
  logic [7:0] ctrlRdData, dpRdData;
  logic       accessEn, promisc, vlanFiltEn;

  cam_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .stb(stb), .ctrlRdData(ctrlRdData), .accessEn(accessEn),
    .promisc(promisc), .vlanFiltEn(vlanFiltEn)
  );

  cam_match_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .hdrValid(hdrValid), .hdrDa(hdrDa), .hdrTagged(hdrTagged), .hdrVid(hdrVid),
    .promisc(promisc), .vlanFiltEn(vlanFiltEn), .dpRdData(dpRdData),
    .resultValid(resultValid), .mcHit(mcHit), .vlanHit(vlanHit), .accept(accept)
  );

  assign regRdData = (regAddr < ADDR_CTRL) ? (accessEn ? dpRdData : 8'h00)
                                           : ctrlRdData;

  // R9
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && promisc) |=> accept);
endmodule

// File: tb/rx_cam_filter_bench.sv
module rx_cam_filter_bench;
  localparam logic [7:0] A_CTRL = 8'h0C;
  localparam logic [7:0] A_IDX  = 8'h0D;
  localparam logic [7:0] A_CFG  = 8'h0E;
  localparam logic [7:0] A_MASK = 8'h08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0, regRdData;
  logic regWr = 1'b0;
  logic hdrValid = 1'b0, hdrTagged = 1'b0;
  logic [47:0] hdrDa = '0;
  logic [11:0] hdrVid = '0;
  logic resultValid, mcHit, vlanHit, accept;

  always #4 clk = ~clk;

  rx_cam_filter u_rx_cam_filter (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRdData(regRdData), .hdrValid(hdrValid), .hdrDa(hdrDa),
    .hdrTagged(hdrTagged), .hdrVid(hdrVid), .resultValid(resultValid),
    .mcHit(mcHit), .vlanHit(vlanHit), .accept(accept)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct { bit mc; bit vl; bit acc; string req; } exp_t;
  exp_t expQ[$];

  logic [47:0] sMc [32];
  logic [15:0] sVl [32];
  logic [31:0] sMcMask = '0, sVlMask = '0;
  bit sProm = 0, sVf = 0;

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [47:0] da, input bit tg, input logic [11:0] vid, input string req);
    exp_t e;
    bit grp, anyMc, anyVl;
    grp = da[40];
    anyMc = 0; anyVl = 0;
    for (int i = 0; i < 32; i++) begin
      if (sMcMask[i] && sMc[i] == da) anyMc = 1;
      if (sVlMask[i] && sVl[i][11:0] == vid) anyVl = 1;
    end
    e.mc  = grp && ((&da) || anyMc);
    e.vl  = tg && anyVl;
    e.acc = sProm || ((!grp || e.mc) && (!sVf || !tg || e.vl));
    e.req = req;
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        checkVal({e.req, " mcHit"}, mcHit, e.mc);
        checkVal({e.req, " vlanHit"}, vlanHit, e.vl);
        checkVal({e.req, " accept"}, accept, e.acc);
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic sendHdr(input logic [47:0] da, input bit tg, input logic [11:0] vid, input string req);
    expQ.push_back(model(da, tg, vid, req));
    hdrDa = da; hdrTagged = tg; hdrVid = vid; hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  task automatic progMc(input logic [7:0] idx, input logic [47:0] da);
    regWrite(A_CTRL, 8'h01);
    regWrite(A_IDX, idx);
    for (int b = 0; b < 6; b++) regWrite(8'(b), da[47-8*b -: 8]);
    regWrite(A_CTRL, 8'h05);
    regWrite(A_CTRL, 8'h00);
    sMc[idx[4:0]] = da;
  endtask

  task automatic progVl(input logic [7:0] idx, input logic [15:0] v);
    regWrite(A_CTRL, 8'h03);
    regWrite(A_IDX, idx);
    regWrite(8'h06, v[7:0]);
    regWrite(8'h07, v[15:8]);
    regWrite(A_CTRL, 8'h07);
    regWrite(A_CTRL, 8'h00);
    sVl[idx[4:0]] = v;
  endtask

  task automatic setMask(input bit vl, input logic [31:0] m);
    regWrite(A_CTRL, vl ? 8'h03 : 8'h01);
    for (int b = 0; b < 4; b++) regWrite(A_MASK + 8'(b), m[8*b +: 8]);
    regWrite(A_CTRL, 8'h00);
    if (vl) sVlMask = m; else sMcMask = m;
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10 missing results actual=0 expected=%0d", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [47:0] MC_A = 48'h01005E000001;
  localparam logic [47:0] MC_B = 48'h333300000002;
  localparam logic [47:0] MC_C = 48'h01005E7F00AA;
  localparam logic [47:0] UC_X = 48'h0010A4112233;

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 32; i++) begin sMc[i] = '0; sVl[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(A_CTRL, rd); checkVal("R1 ctrl", rd, 8'h00);
    regRead(A_CFG, rd);  checkVal("R1 cfg", rd, 8'h00);
    regWrite(A_CTRL, 8'h01);
    regRead(A_IDX, rd);  checkVal("R1 index", rd, 8'h00);
    for (int b = 0; b < 4; b++) begin
      regRead(A_MASK + 8'(b), rd); checkVal("R1 mc mask", rd, 8'h00);
    end
    regWrite(A_CTRL, 8'h03);
    for (int b = 0; b < 4; b++) begin
      regRead(A_MASK + 8'(b), rd); checkVal("R1 vlan mask", rd, 8'h00);
    end
    regWrite(A_CTRL, 8'h00);
    sendHdr(48'h000000000001 | (48'h01 << 40), 1'b1, 12'h000, "R1 no hit");
    sendHdr(48'hFFFFFFFFFFFF, 1'b0, 12'h000, "R7 broadcast");

    // R2: access gating
    regWrite(8'h00, 8'hAA);
    regRead(8'h00, rd); checkVal("R2 closed read", rd, 8'h00);
    regWrite(A_CTRL, 8'h01);
    regRead(8'h00, rd); checkVal("R2 ignored write", rd, 8'h00);
    regWrite(A_CTRL, 8'h00);

    // R4 / R6 / R7: multicast table
    progMc(8'd0, MC_A);
    progMc(8'd5, MC_B);
    progMc(8'd7, UC_X);
    sendHdr(MC_A, 1'b0, 12'h0, "R6 masked off");
    setMask(1'b0, 32'h0000_0001);
    sendHdr(MC_A, 1'b0, 12'h0, "R7 entry0 hit");
    sendHdr(MC_B, 1'b0, 12'h0, "R7 entry5 masked");
    setMask(1'b0, 32'h0000_00A1);
    sendHdr(MC_B, 1'b0, 12'h0, "R7 entry5 hit");
    sendHdr(UC_X, 1'b0, 12'h0, "R7 unicast entry");
    regWrite(A_CTRL, 8'h01);
    regRead(A_MASK, rd); checkVal("R6 mc mask byte0", rd, 8'hA1);
    regWrite(A_CTRL, 8'h00);

    // R8 / R9: VLAN table and filter
    progVl(8'd2, 16'hF064);
    setMask(1'b1, 32'h0000_0004);
    regWrite(A_CTRL, 8'h03);
    regRead(A_MASK, rd); checkVal("R6 vlan mask byte0", rd, 8'h04);
    regWrite(A_CTRL, 8'h00);
    regWrite(A_CFG, 8'h80); sVf = 1;
    regRead(A_CFG, rd); checkVal("R9 cfg readback", rd, 8'h80);
    sendHdr(UC_X, 1'b1, 12'h064, "R8 vid hit");
    sendHdr(UC_X, 1'b1, 12'h065, "R9 vid reject");
    sendHdr(UC_X, 1'b0, 12'h065, "R9 untagged pass");
    sendHdr(MC_C, 1'b1, 12'h064, "R9 mc miss reject");
    regWrite(A_CFG, 8'h00); sVf = 0;
    sendHdr(UC_X, 1'b1, 12'h065, "R9 filter off");
    regWrite(A_CFG, 8'h81); sProm = 1; sVf = 1;
    sendHdr(MC_C, 1'b1, 12'h065, "R9 promiscuous");
    regWrite(A_CFG, 8'h00); sProm = 0; sVf = 0;

    // R3 / R5: index wrap and read strobe
    regWrite(A_CTRL, 8'h01);
    regWrite(A_IDX, 8'd37);
    regRead(A_IDX, rd); checkVal("R3 index wrap", rd, 8'h05);
    regWrite(A_CTRL, 8'h09);
    @(negedge clk);
    regRead(A_CTRL, rd); checkVal("R5 strobe cleared", rd, 8'h01);
    for (int b = 0; b < 6; b++) begin
      regRead(8'(b), rd); checkVal("R5 mc readback", rd, MC_B[47-8*b -: 8]);
    end
    regWrite(A_CTRL, 8'h03);
    regWrite(A_IDX, 8'd2);
    regWrite(A_CTRL, 8'h0B);
    @(negedge clk);
    regRead(8'h06, rd); checkVal("R5 vlan low", rd, 8'h64);
    regRead(8'h07, rd); checkVal("R5 vlan high", rd, 8'hF0);
    regWrite(A_CTRL, 8'h00);

    // R10: write landing on the same edge as a header
    setMask(1'b0, 32'h0000_02A1);
    progMc(8'd9, MC_A);
    regWrite(A_CTRL, 8'h01);
    regWrite(A_IDX, 8'd9);
    for (int b = 0; b < 6; b++) regWrite(8'(b), MC_C[47-8*b -: 8]);
    regWrite(A_CTRL, 8'h05);
    sendHdr(MC_C, 1'b0, 12'h0, "R10 same edge old");
    sMc[9] = MC_C;
    regWrite(A_CTRL, 8'h00);
    sendHdr(MC_C, 1'b0, 12'h0, "R10 next frame new");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule